// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a target-only SMBus engine in front of a small control register file for a clock buffer. It watches oversampled SCL and SDA lines, answers one fixed 7-bit address, and carries out indexed block writes and indexed block reads. Each transfer names a starting register and a byte count. Successive data bytes then go to, or come from, successive registers. SDA is driven only through an open-drain enable, where a 1 pulls the line low.

The register file has six bytes: a control byte, two spare read/write bytes, a revision/vendor identity byte, a device identity byte, and a byte that sets the count reported on block reads. Two resolved outputs, loop-bandwidth select and PLL-on, come either from the control byte or from two pins. A steering bit in the control byte chooses the source.

Top module: `smb_regfile_target`

## Requirements
- R1: The target acknowledges only address 7'h6A (address byte 0xD4 with bit 0 = 0 for write, 0xD5 with bit 0 = 1 for read). Any other address byte gets no acknowledge, and the bus is then ignored until the next START.
- R2: In a write (address, offset, count N, N data bytes), every byte is acknowledged. Data byte i is stored at register offset+i.
- R3: A write count byte of 0x00 is not acknowledged. Nothing is stored, and later bytes are ignored until the next START.
- R4: Data bytes past the declared count are not acknowledged and are discarded.
- R5: A read is a write-addressed offset, then a repeated START and 0xD5. The target then returns the value of register 5 as a count byte, followed by registers offset, offset+1, and so on, for as long as the master acknowledges. A master NACK ends the transfer.
- R6: Reset values, by offset: 0 = 0x83, 1 = 0x00, 2 = 0x00, 3 = 0x00, 4 = 0x06, 5 = 0x06.
- R7: Writes to offsets 3 and 4 are acknowledged but leave them unchanged. Offsets 6 to 255 are acknowledged on write, store nothing, and read as 0x00.
- R8: When register 0 bit 7 is 1, bw_high_o follows pin_bw_i and pll_on_o follows pin_pll_on_i. When it is 0, bw_high_o is register 0 bit 1 and pll_on_o is register 0 bit 0.
- R9: A START in mid-transfer restarts address decoding. A STOP returns the target to idle with SDA released. A byte cut short by either stores nothing.
- R10: Apart from the release forced by START or STOP, the SDA drive changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| pin_bw_i | input | 1 | Pin-level bandwidth select |
| pin_pll_on_i | input | 1 | Pin-level PLL enable |
| bw_high_o | output | 1 | Resolved bandwidth select (1 = high) |
| pll_on_o | output | 1 | Resolved PLL enable (0 = bypass) |

## Verification
The hardest states to reach from the ports are the ones where a transfer is cut off or runs past its limits. Examples are a START arriving after a data byte has been acknowledged but before the declared count is used up, a STOP in the middle of a byte, and a data byte sent after a zero count. The bench drives a bit-level master model that can stop at any bit. It then reads the registers back to show that only completed, in-count bytes were stored. Random block writes at random offsets also rewrite the read-count and steering registers. Their effect is then observed on the count byte of the next read and on the resolved outputs.

// File: rtl/smbr_pkg.sv
package smbr_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_OFFS, ST_WCNT, ST_WDATA, ST_TX
  } phase_e;
endpackage

// File: rtl/smbr_edge.sv
module smbr_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_o;
      sda_d  <= sda_o;
    end
  end

  assign scl_o      = scl_sh[STAGES-1];
  assign sda_o      = sda_sh[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // SDA edges while SCL stays high
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/smbr_regs.sv
module smbr_regs
  import smbr_pkg::*;
#(
  parameter int    NREGS   = 6,
  parameter byte_t DEV_ID  = 8'h06,
  parameter logic [3:0] REV_ID = 4'h0,
  parameter logic [3:0] VEN_ID = 4'h0,
  parameter byte_t CNT_RST = 8'h06
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  byte_t wr_addr_i,
  input  byte_t wr_data_i,
  input  byte_t rd_addr_i,
  output byte_t rd_data_o,
  output byte_t rb_cnt_o,
  input  logic  pin_bw_i,
  input  logic  pin_pll_on_i,
  output logic  bw_high_o,
  output logic  pll_on_o
);
  localparam int CTL_IX = 0;
  localparam int CNT_IX = 5;
  localparam logic [NREGS-1:0] RW_MASK = NREGS'(6'b100111);

  function automatic byte_t rst_val(input int ix);
    case (ix)
      CTL_IX:  return 8'h83;
      3:       return {REV_ID, VEN_ID};
      4:       return DEV_ID;
      CNT_IX:  return CNT_RST;
      default: return 8'h00;
    endcase
  endfunction

  logic [NREGS-1:0][BYTE_W-1:0] regs;

  for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
    if (RW_MASK[gi]) begin : g_rw
      byte_t q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= rst_val(gi);
        else if (wr_en_i && wr_addr_i == 8'(gi)) q <= wr_data_i;
      end
      assign regs[gi] = q;
    end else begin : g_ro
      assign regs[gi] = rst_val(gi);
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NREGS; i++)
      if (rd_addr_i == 8'(i)) rd_data_o = regs[i];
  end

  assign rb_cnt_o  = regs[CNT_IX];
  assign bw_high_o = regs[CTL_IX][7] ? pin_bw_i     : regs[CTL_IX][1];
  assign pll_on_o  = regs[CTL_IX][7] ? pin_pll_on_i : regs[CTL_IX][0];

  // R2
  rw_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 8'd1) |=> regs[1] == $past(wr_data_i));
endmodule

// File: rtl/smbr_ctrl.sv
module smbr_ctrl
  import smbr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6A
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  scl_s_i,
  input  logic  sda_s_i,
  input  logic  scl_rise_i,
  input  logic  scl_fall_i,
  input  logic  start_i,
  input  logic  stop_i,
  input  byte_t rd_data_i,
  input  byte_t rb_cnt_i,
  output logic  sda_oe_o,
  output logic  wr_en_o,
  output byte_t wr_addr_o,
  output byte_t wr_data_o,
  output byte_t rd_addr_o
);
  localparam logic [3:0] ACK_BIT = 4'd8;
  localparam logic [3:0] END_BIT = 4'd9;

  phase_e     phase_q, nxt_q;
  logic [3:0] bit_q;
  byte_t      rx_q, tx_q, ptr_q, rem_q;
  logic       oe_q, mnack_q;
  logic       ack_begin;

  assign ack_begin = scl_fall_i && bit_q == ACK_BIT && phase_q != ST_IDLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= ST_IDLE;
      nxt_q   <= ST_IDLE;
      bit_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      rem_q   <= '0;
      oe_q    <= 1'b0;
      mnack_q <= 1'b1;
    end else if (start_i) begin
      phase_q <= ST_ADDR;
      bit_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_i) begin
      phase_q <= ST_IDLE;
      bit_q   <= '0;
      oe_q    <= 1'b0;
    end else if (phase_q != ST_IDLE) begin
      if (scl_rise_i) begin
        if (bit_q < ACK_BIT) begin
          rx_q  <= {rx_q[6:0], sda_s_i};
          bit_q <= bit_q + 4'd1;
        end else if (bit_q == ACK_BIT) begin
          mnack_q <= sda_s_i;
          bit_q   <= END_BIT;
        end
      end else if (scl_fall_i) begin
        if (phase_q == ST_TX) begin
          if (bit_q < ACK_BIT) oe_q <= ~tx_q[~bit_q[2:0]];
          else if (bit_q == ACK_BIT) oe_q <= 1'b0;
          else begin
            bit_q <= '0;
            if (mnack_q) begin
              phase_q <= ST_IDLE;
              oe_q    <= 1'b0;
            end else begin
              tx_q  <= rd_data_i;
              ptr_q <= ptr_q + 8'd1;
              oe_q  <= ~rd_data_i[7];
            end
          end
        end else if (bit_q == ACK_BIT) begin
          oe_q  <= 1'b0;
          nxt_q <= ST_IDLE;
          unique case (phase_q)
            ST_ADDR: if (rx_q[7:1] == DEV_ADDR) begin
              oe_q  <= 1'b1;
              nxt_q <= rx_q[0] ? ST_TX : ST_OFFS;
            end
            ST_OFFS: begin
              oe_q  <= 1'b1;
              ptr_q <= rx_q;
              nxt_q <= ST_WCNT;
            end
            ST_WCNT: if (rx_q != 8'h00) begin
              oe_q  <= 1'b1;
              rem_q <= rx_q;
              nxt_q <= ST_WDATA;
            end
            ST_WDATA: if (rem_q != 8'h00) begin
              oe_q  <= 1'b1;
              ptr_q <= ptr_q + 8'd1;
              rem_q <= rem_q - 8'd1;
              nxt_q <= ST_WDATA;
            end
            default: ;
          endcase
        end else if (bit_q == END_BIT) begin
          bit_q   <= '0;
          phase_q <= nxt_q;
          oe_q    <= 1'b0;
          if (nxt_q == ST_TX) begin
            tx_q <= rb_cnt_i;
            oe_q <= ~rb_cnt_i[7];
          end
        end
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_en_o   = ack_begin && phase_q == ST_WDATA && rem_q != 8'h00;
  assign wr_addr_o = ptr_q;
  assign wr_data_o = rx_q;
  assign rd_addr_o = ptr_q;

  // R9
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (phase_q == ST_IDLE && !sda_oe_o));
  // R3
  zero_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_begin && phase_q == ST_WCNT && rx_q == 8'h00) |=> (!sda_oe_o && nxt_q == ST_IDLE));
  // R1
  addr_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_begin && phase_q == ST_ADDR && rx_q[7:1] != DEV_ADDR) |=> !sda_oe_o);
  // R4
  over_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_begin && phase_q == ST_WDATA && rem_q == 8'h00) |=> !sda_oe_o);
  // R10
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_o) && !$past(start_i || stop_i)) |-> !$past(scl_s_i));
endmodule

// File: rtl/smb_regfile_target.sv
module smb_regfile_target
  import smbr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6A,
  parameter int         STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  input  logic pin_bw_i,
  input  logic pin_pll_on_i,
  output logic bw_high_o,
  output logic pll_on_o
);
  logic  scl_s, sda_s, scl_rise, scl_fall, start, stop, wr_en;
  byte_t wr_addr, wr_data, rd_addr, rd_data, rb_cnt;

  smbr_edge #(.STAGES(STAGES)) u_edge (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  smbr_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk_i, .rst_ni, .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start), .stop_i(stop),
    .rd_data_i(rd_data), .rb_cnt_i(rb_cnt), .sda_oe_o,
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .rd_addr_o(rd_addr)
  );

  smbr_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rb_cnt_o(rb_cnt),
    .pin_bw_i, .pin_pll_on_i, .bw_high_o, .pll_on_o
  );
endmodule

// File: tb/smb_regfile_target_test.sv
module smb_regfile_target_test;
  localparam int Q = 5;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic pin_bw = 1'b0, pin_pll = 1'b0;
  logic sda_oe, bw_high, pll_on;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0;
  logic [7:0] expr [0:5];
  logic [7:0] wbuf [0:7];

  always #10 clk = ~clk;

  smb_regfile_target uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .pin_bw_i(pin_bw), .pin_pll_on_i(pin_pll), .bw_high_o(bw_high), .pll_on_o(pll_on)
  );

  function automatic logic [7:0] mread(input logic [7:0] a);
    return (a < 8'd6) ? expr[a] : 8'h00;
  endfunction

  function automatic logic writable(input logic [7:0] a);
    return a == 8'd0 || a == 8'd1 || a == 8'd2 || a == 8'd5;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic hw(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; hw(); scl = 1'b1; hw(); sda_m = 1'b0; hw(); scl = 1'b0; hw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hw(); scl = 1'b1; hw(); sda_m = 1'b1; hw(); hw();
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_m = b[i]; hw(); scl = 1'b1; hw(); hw(); scl = 1'b0; hw();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; hw(); scl = 1'b1; hw(); ack = ~sda_line; hw(); scl = 1'b0; hw();
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(); scl = 1'b1; hw(); b[i] = sda_line; hw(); scl = 1'b0;
    end
    sda_m = nack; hw(); scl = 1'b1; hw(); hw(); scl = 1'b0; hw(); sda_m = 1'b1;
  endtask

  // write n declared, nsend actually sent; model updates only acked in-count bytes
  task automatic wr_txn(input string req, input logic [7:0] off, input int n, input int nsend);
    logic ack;
    bus_start();
    send_byte(8'hD4, ack); check({req, " addr ack"}, 8'(ack), 8'd1);
    send_byte(off, ack);   check({req, " offset ack"}, 8'(ack), 8'd1);
    send_byte(8'(n), ack); check({req, " count ack"}, 8'(ack), 8'(n != 0));
    for (int i = 0; i < nsend; i++) begin
      send_byte(wbuf[i], ack);
      check({req, " data ack"}, 8'(ack), 8'(n != 0 && i < n));
      if (n != 0 && i < n && writable(off + 8'(i))) expr[off + 8'(i)] = wbuf[i];
    end
    bus_stop();
  endtask

  task automatic rd_txn(input string req, input logic [7:0] off, input int k);
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD4, ack); check({req, " rd addr ack"}, 8'(ack), 8'd1);
    send_byte(off, ack);   check({req, " rd offset ack"}, 8'(ack), 8'd1);
    bus_start();
    send_byte(8'hD5, ack); check({req, " rd addr5 ack"}, 8'(ack), 8'd1);
    recv_byte(1'b0, b);    check("R5 count byte", b, expr[5]);
    for (int i = 0; i < k; i++) begin
      recv_byte(i == k - 1, b);
      check({req, " read data"}, b, mread(off + 8'(i)));
    end
    bus_stop();
  endtask

  task automatic chk_outs(input string req);
    repeat (3) @(negedge clk);
    check({req, " bw"}, 8'(bw_high), 8'(expr[0][7] ? pin_bw : expr[0][1]));
    check({req, " pll"}, 8'(pll_on), 8'(expr[0][7] ? pin_pll : expr[0][0]));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    void'($urandom(32'd7341));
    expr[0] = 8'h83; expr[1] = 8'h00; expr[2] = 8'h00;
    expr[3] = 8'h00; expr[4] = 8'h06; expr[5] = 8'h06;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 sda released", 8'(sda_oe), 8'd0);
    // R8 pin steering after reset
    pin_bw = 1'b0; pin_pll = 1'b1; chk_outs("R8 pins");
    pin_bw = 1'b1; pin_pll = 1'b0; chk_outs("R8 pins");
    rd_txn("R6", 8'd0, 6);

    // R1 foreign addresses
    bus_start();
    send_byte(8'hA0, ack); check("R1 foreign addr nack", 8'(ack), 8'd0);
    send_byte(8'h00, ack); check("R1 ignored after miss", 8'(ack), 8'd0);
    bus_stop();
    bus_start();
    send_byte(8'hD6, ack); check("R1 near addr nack", 8'(ack), 8'd0);
    bus_stop();

    // R8 register steering
    wbuf[0] = 8'h00; wr_txn("R8", 8'd0, 1, 1); chk_outs("R8 regs 00");
    wbuf[0] = 8'h03; wr_txn("R8", 8'd0, 1, 1); chk_outs("R8 regs 03");

    // R7 read-only and out-of-range offsets
    wbuf[0] = 8'hFF; wbuf[1] = 8'hFF; wbuf[2] = 8'hA5;
    wr_txn("R7", 8'd3, 3, 3);
    rd_txn("R7", 8'd3, 4);
    wbuf[0] = 8'h77; wr_txn("R7", 8'hF0, 1, 1);
    rd_txn("R7", 8'hF0, 2);

    // R3 zero count: stray byte after it must not land
    wbuf[0] = 8'h99; wr_txn("R3", 8'd1, 0, 1);
    rd_txn("R3", 8'd1, 1);

    // R4 extra bytes past the count
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wr_txn("R4", 8'd1, 1, 2);
    rd_txn("R4", 8'd1, 2);

    // R9 START after a data byte, then STOP mid-byte
    bus_start();
    send_byte(8'hD4, ack); send_byte(8'd1, ack); send_byte(8'd3, ack);
    send_byte(8'h5A, ack); check("R9 first data ack", 8'(ack), 8'd1);
    expr[1] = 8'h5A;
    bus_start();
    send_byte(8'hD4, ack); check("R9 restart addr ack", 8'(ack), 8'd1);
    send_byte(8'd2, ack); send_byte(8'd1, ack);
    send_bits(8'hC3, 4);
    bus_stop();
    check("R9 sda released", 8'(sda_oe), 8'd0);
    rd_txn("R9", 8'd0, 3);

    // R5 readback count register
    wbuf[0] = 8'h02; wr_txn("R5", 8'd5, 1, 1);
    rd_txn("R5", 8'd4, 2);

    // R2 random block writes and reads
    for (int it = 0; it < 20; it++) begin
      automatic logic [7:0] off = 8'($urandom_range(0, 7));
      automatic int n = $urandom_range(1, 4);
      for (int j = 0; j < 8; j++) wbuf[j] = 8'($urandom);
      wr_txn("R2", off, n, n);
      pin_bw = 1'($urandom); pin_pll = 1'($urandom);
      chk_outs("R8 random");
      rd_txn("R2", 8'($urandom_range(0, 7)), $urandom_range(1, 6));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule